// File: doc/BRIEF.md
# Board Control and Timebase Register File

This block is a small control and status register file on a simple 32-bit register bus with separate setup and access phases, in the style of APB. It sits in a 4 KiB window with little-endian byte order. Software uses it to drive two user LEDs, read a set of push buttons, keep a free-form 32-bit control word for neighbouring logic, and read or set two free-running timebases: one that counts seconds and one that counts hundredths of a second. It also holds a prescaled event counter. A down-counter is stepped by the reference tick, and each time it passes through zero the counter advances by one.

All counting is driven by a reference clock enable, `ref_tick`, which is high for one clock per reference period. The parameter `TICKS_PER_SEC` gives how many reference ticks make one second. The dividers of both timebases are derived from it, so each count lasts exactly one second or one hundredth of a second. Accesses to offsets that are not decoded, and writes to read-only registers, raise an error flag during the access phase. They change nothing.

Top module: `brdctl_top`

## Requirements
- R1: After synchronous reset, every readable register reads zero (buttons apart) and `led_o` is 0: LED, control word, both timebases, event counter, reload value and down-counter.
- R2: A write to offset 0x000 keeps only data bits [1:0]. `led_o[0]` follows bit 0 and `led_o[1]` follows bit 1, both active high, from the clock edge that ends the access phase. A read returns the two bits in [1:0] with zeros above.
- R3: The control word at offset 0x04C returns exactly the 32-bit value last written.
- R4: The seconds timebase at offset 0x010 increments by one, wrapping at 2^32, after every `TICKS_PER_SEC` reference ticks.
- R5: The hundredths timebase at offset 0x014 increments by one, wrapping at 2^32, after every `TICKS_PER_SEC/100` reference ticks.
- R6: Writing a timebase sets its count to the written value and restarts its divider. The next increment comes after a full period of ticks.
- R7: The button inputs are read at offset 0x008 in bits [BTN_N-1:0] through a two-flop synchroniser. A change on `btn_i` shows in the read data after the second rising clock edge, and not after the first.
- R8: The down-counter (read-only, offset 0x020) decrements on each reference tick while it is non-zero. On a tick while it is zero, it reloads from the reload value and the event counter (offset 0x018) increments. With a reload value of zero, the event counter therefore increments on every tick.
- R9: Writing the reload value (offset 0x01C) loads both the reload register and the down-counter. Writing offset 0x018 sets the event counter. Both registers read back as written.
- R10: An access to any offset outside {0x000, 0x008, 0x010, 0x014, 0x018, 0x01C, 0x020, 0x04C}, including misaligned ones, raises `pslverr` during the access phase and reads as zero. The same flag is raised for a write to 0x008 or 0x020. Such accesses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_tick | input | 1 | Reference clock enable, one pulse per reference period |
| psel | input | 1 | Bus select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high and pwrite is low |
| pslverr | output | 1 | Error flag for a bad access, high during its access phase |
| btn_i | input | 4 | Asynchronous push-button inputs |
| led_o | output | 2 | LED drives, active high |

## Verification
A write takes effect at the rising edge that closes its access phase. The bench reads back one falling edge later or more. Read data and the error flag are combinational within the access phase, so they are sampled shortly after the falling edge that starts it. Each reference tick is held high across exactly one rising edge, and every register is predicted by a per-tick bench model that counts those edges. The button path is checked by holding a read select steady and sampling before the first, after the first and after the second rising edge that follows an input change.

// File: rtl/brdctl_pkg.sv
// Package: shared register selector type and offset decode for the board
// control register file. Assumes a 4 KiB window addressed by byte offset,
// with only word-aligned offsets decoded.
package brdctl_pkg;

    localparam int WIN_AW = 12;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_LED,
        SEL_BTN,
        SEL_SEC,
        SEL_CSEC,
        SEL_EVT,
        SEL_RELOAD,
        SEL_DOWN,
        SEL_CTRL
    } rsel_e;

    localparam logic [WIN_AW-1:0] OFS_LED    = 12'h000;
    localparam logic [WIN_AW-1:0] OFS_BTN    = 12'h008;
    localparam logic [WIN_AW-1:0] OFS_SEC    = 12'h010;
    localparam logic [WIN_AW-1:0] OFS_CSEC   = 12'h014;
    localparam logic [WIN_AW-1:0] OFS_EVT    = 12'h018;
    localparam logic [WIN_AW-1:0] OFS_RELOAD = 12'h01C;
    localparam logic [WIN_AW-1:0] OFS_DOWN   = 12'h020;
    localparam logic [WIN_AW-1:0] OFS_CTRL   = 12'h04C;

    // Map a byte offset to a register selector; unmatched offsets give SEL_NONE.
    function automatic rsel_e decode_ofs(input logic [WIN_AW-1:0] ofs);
        rsel_e s;
        case (ofs)
            OFS_LED:    s = SEL_LED;
            OFS_BTN:    s = SEL_BTN;
            OFS_SEC:    s = SEL_SEC;
            OFS_CSEC:   s = SEL_CSEC;
            OFS_EVT:    s = SEL_EVT;
            OFS_RELOAD: s = SEL_RELOAD;
            OFS_DOWN:   s = SEL_DOWN;
            OFS_CTRL:   s = SEL_CTRL;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Registers that software may read but not write.
    function automatic logic is_read_only(input rsel_e s);
        return (s == SEL_BTN) || (s == SEL_DOWN);
    endfunction

endpackage

// File: rtl/brdctl_timebase.sv
// Module: loadable free-running counter that advances once every DIV
// reference ticks. A load sets the count and restarts the divider phase,
// so the first increment after a load needs a full DIV ticks.
// Assumes tick is a single-cycle enable and DIV >= 1.
module brdctl_timebase #(
    parameter int DATA_W = 32,
    parameter int DIV    = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_val,
    output logic [DATA_W-1:0] count
);

    localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

    logic [PH_W-1:0] phase;

    // Divider phase and count: load wins, otherwise step on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            count <= '0;
        end else if (ld) begin
            phase <= '0;
            count <= ld_val;
        end else if (tick) begin
            if (phase == PH_LAST) begin
                phase <= '0;
                count <= count + 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    AST_TB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !tick) |=> (count == $past(count)));  // R4
    AST_TB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (count == $past(ld_val)) && (phase == '0));  // R6
    AST_TB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld && phase == PH_LAST) |=> (count == $past(count) + 1'b1));  // R5
    AST_TB_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= PH_LAST);  // R4

endmodule

// File: rtl/brdctl_prescnt.sv
// Module: prescaled event counter. A down-counter steps on each reference
// tick; on a tick while it is zero it reloads from the reload register and
// the event counter increments. Writing the reload value also loads the
// down-counter and suppresses that cycle's step. Assumes single-cycle ticks.
module brdctl_prescnt #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reload_ld,
    input  logic              evt_ld,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] reload_q,
    output logic [DATA_W-1:0] down_q,
    output logic [DATA_W-1:0] evt_q
);

    logic at_zero;
    assign at_zero = (down_q == '0);

    // Reload register: written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '0;
        else if (reload_ld) reload_q <= wdata;
    end

    // Down-counter: software load, else decrement or reload on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)         down_q <= '0;
        else if (reload_ld) down_q <= wdata;
        else if (tick)      down_q <= at_zero ? reload_q : down_q - 1'b1;
    end

    // Event counter: software load, else increment on a tick taken at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                             evt_q <= '0;
        else if (evt_ld)                        evt_q <= wdata;
        else if (tick && at_zero && !reload_ld) evt_q <= evt_q + 1'b1;
    end

    AST_PS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reload_ld && down_q != '0) |=> (down_q == $past(down_q) - 1'b1));  // R8
    AST_PS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reload_ld && down_q == '0) |=> (down_q == $past(reload_q)));  // R8
    AST_PS_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_ld && !tick) |=> $stable(evt_q));  // R8
    AST_PS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reload_ld |=> (down_q == $past(wdata)) && (reload_q == $past(wdata)));  // R9

endmodule

// File: rtl/brdctl_btnsync.sv
// Module: multi-flop synchroniser for a bus of asynchronous level inputs.
// Each bit is treated independently; no debouncing is done.
module brdctl_btnsync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage [STAGES];

    // Shift the inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q_o = stage[STAGES-1];

endmodule

// File: rtl/brdctl_top.sv
// Module: board control and timebase register file on a two-phase register
// bus. Writes commit at the edge ending the access phase. Read data is
// combinational while psel is high and pwrite low. Bad accesses raise
// pslverr in the access phase and have no side effect.
// Assumes TICKS_PER_SEC is a multiple of FAST_RATE.
module brdctl_top
    import brdctl_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int LED_N         = 2,
    parameter int BTN_N         = 4,
    parameter int TICKS_PER_SEC = 1000,
    parameter int FAST_RATE     = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_tick,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [WIN_AW-1:0]   paddr,
    input  logic [DATA_W-1:0]   pwdata,
    output logic [DATA_W-1:0]   prdata,
    output logic                pslverr,
    input  logic [BTN_N-1:0]    btn_i,
    output logic [LED_N-1:0]    led_o
);

    localparam int DIV_SLOW = TICKS_PER_SEC;
    localparam int DIV_FAST = TICKS_PER_SEC / FAST_RATE;
    localparam int N_TB     = 2;

    rsel_e              sel;
    logic               access;
    logic               bad;
    logic               wr_ok;
    logic [LED_N-1:0]   led_q;
    logic [DATA_W-1:0]  ctrl_q;
    logic [BTN_N-1:0]   btn_s;
    logic [DATA_W-1:0]  tb_cnt [N_TB];
    logic [DATA_W-1:0]  reload_q, down_q, evt_q;

    // Decode the offset and qualify the access.
    assign sel     = decode_ofs(paddr);
    assign access  = psel && penable;
    assign bad     = (sel == SEL_NONE) || (pwrite && is_read_only(sel));
    assign pslverr = access && bad;
    assign wr_ok   = access && pwrite && !bad;

    // LED register: keep only the low LED_N bits of the write data.
    always_ff @(posedge clk) begin
        if (!rst_n)                          led_q <= '0;
        else if (wr_ok && sel == SEL_LED)    led_q <= pwdata[LED_N-1:0];
    end
    assign led_o = led_q;

    // Control word: plain storage, read back as written.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl_q <= '0;
        else if (wr_ok && sel == SEL_CTRL)   ctrl_q <= pwdata;
    end

    brdctl_btnsync #(.W(BTN_N), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (btn_i),
        .q_o   (btn_s)
    );

    // Two timebases sharing one structure; index 0 is seconds, 1 is hundredths.
    for (genvar g = 0; g < N_TB; g++) begin : g_tb
        localparam int    DIV_G = (g == 0) ? DIV_SLOW : DIV_FAST;
        localparam rsel_e SEL_G = (g == 0) ? SEL_SEC : SEL_CSEC;
        brdctl_timebase #(.DATA_W(DATA_W), .DIV(DIV_G)) u_tb (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (ref_tick),
            .ld     (wr_ok && sel == SEL_G),
            .ld_val (pwdata),
            .count  (tb_cnt[g])
        );
    end

    brdctl_prescnt #(.DATA_W(DATA_W)) u_ps (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (ref_tick),
        .reload_ld (wr_ok && sel == SEL_RELOAD),
        .evt_ld    (wr_ok && sel == SEL_EVT),
        .wdata     (pwdata),
        .reload_q  (reload_q),
        .down_q    (down_q),
        .evt_q     (evt_q)
    );

    // Read multiplexer: zero when not reading or when the offset is undecoded.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (sel)
                SEL_LED:    prdata[LED_N-1:0] = led_q;
                SEL_BTN:    prdata[BTN_N-1:0] = btn_s;
                SEL_SEC:    prdata = tb_cnt[0];
                SEL_CSEC:   prdata = tb_cnt[1];
                SEL_EVT:    prdata = evt_q;
                SEL_RELOAD: prdata = reload_q;
                SEL_DOWN:   prdata = down_q;
                SEL_CTRL:   prdata = ctrl_q;
                default:    prdata = '0;
            endcase
        end
    end

    AST_ERR_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |=> $stable(led_o) && $stable(ctrl_q) && $stable(reload_q));  // R10
    AST_ERR_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        (pslverr && !pwrite) |-> (prdata == '0));  // R10
    AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(access && pwrite && paddr == OFS_LED) |=> $stable(led_o));  // R2
    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (access && pwrite && paddr == OFS_CTRL) |=> (ctrl_q == $past(pwdata)));  // R3

endmodule

// File: tb/sim_brdctl_top.sv
module sim_brdctl_top;

    localparam int TPS   = 200;
    localparam int FAST  = 100;
    localparam int DIVF  = TPS / FAST;
    localparam int BTN_N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pslverr;
    logic [BTN_N-1:0] btn_i = '0;
    logic [1:0]  led_o;

    always #4 clk = ~clk;

    brdctl_top #(.TICKS_PER_SEC(TPS), .FAST_RATE(FAST), .BTN_N(BTN_N)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
        .btn_i(btn_i), .led_o(led_o)
    );

    int vecs = 0;
    int miss = 0;
    bit done = 1'b0;

    // Bench model of the programmer-visible state.
    logic [1:0]  m_led;
    logic [31:0] m_ctrl, m_sec, m_csec, m_reload, m_down, m_evt;
    int          m_ph_sec, m_ph_csec;
    logic [BTN_N-1:0] m_btn;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit is_dec(input logic [11:0] a);
        case (a)
            12'h000, 12'h008, 12'h010, 12'h014,
            12'h018, 12'h01C, 12'h020, 12'h04C: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit is_ro(input logic [11:0] a);
        return (a == 12'h008) || (a == 12'h020);
    endfunction

    function automatic logic [11:0] ofs_at(input int i);
        case (i % 8)
            0: return 12'h000; 1: return 12'h008; 2: return 12'h010; 3: return 12'h014;
            4: return 12'h018; 5: return 12'h01C; 6: return 12'h020; default: return 12'h04C;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        case (a)
            12'h000: return "R2 led";
            12'h008: return "R7 buttons";
            12'h010: return "R4 seconds";
            12'h014: return "R5 hundredths";
            12'h018: return "R8 event count";
            12'h01C: return "R9 reload";
            12'h020: return "R8 down-counter";
            12'h04C: return "R3 control";
            default: return "R10 undecoded";
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        case (a)
            12'h000: return {30'd0, m_led};
            12'h008: return {{(32-BTN_N){1'b0}}, m_btn};
            12'h010: return m_sec;
            12'h014: return m_csec;
            12'h018: return m_evt;
            12'h01C: return m_reload;
            12'h020: return m_down;
            12'h04C: return m_ctrl;
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        case (a)
            12'h000: m_led = d[1:0];
            12'h010: begin m_sec = d;  m_ph_sec = 0;  end
            12'h014: begin m_csec = d; m_ph_csec = 0; end
            12'h018: m_evt = d;
            12'h01C: begin m_reload = d; m_down = d; end
            12'h04C: m_ctrl = d;
            default: ;
        endcase
    endtask

    task automatic model_tick();
        m_ph_sec++;
        if (m_ph_sec == TPS) begin m_ph_sec = 0; m_sec++; end
        m_ph_csec++;
        if (m_ph_csec == DIVF) begin m_ph_csec = 0; m_csec++; end
        if (m_down == 0) begin m_down = m_reload; m_evt++; end
        else m_down--;
    endtask

    // One bus transfer: setup phase, access phase (sampled), then idle.
    task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic err);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd = prdata; err = pslverr;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] rd; logic err; bit exp_err;
        bus(1'b1, a, d, rd, err);
        exp_err = !is_dec(a) || is_ro(a);
        chk({tag_of(a), " write error flag (R10)"}, {31'd0, err}, {31'd0, exp_err});
        if (!exp_err) model_write(a, d);
    endtask

    task automatic do_read(input string pfx, input logic [11:0] a);
        logic [31:0] rd; logic err;
        bus(1'b0, a, 32'd0, rd, err);
        chk({pfx, tag_of(a), " read"}, rd, exp_rd(a));
        chk({pfx, tag_of(a), " read error flag (R10)"}, {31'd0, err}, {31'd0, !is_dec(a)});
    endtask

    task automatic verify_all(input string pfx);
        for (int i = 0; i < 8; i++) do_read(pfx, ofs_at(i));
        chk({pfx, "R2 led_o pins"}, {30'd0, led_o}, {30'd0, m_led});
    endtask

    task automatic run_ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            ref_tick = 1'b1;
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                model_tick();
            end
            ref_tick = 1'b0;
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            miss++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_led = '0; m_ctrl = '0; m_sec = '0; m_csec = '0; m_reload = '0;
        m_down = '0; m_evt = '0; m_ph_sec = 0; m_ph_csec = 0; m_btn = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        verify_all("R1 reset ");

        // R2: only two LED bits kept, pins follow them
        do_write(12'h000, 32'hFFFF_FFFD);
        chk("R2 led_o after write", {30'd0, led_o}, 32'd1);
        do_read("", 12'h000);
        do_write(12'h000, 32'h0000_0002);
        chk("R2 led_o bit1 only", {30'd0, led_o}, 32'd2);

        // R3: control word round trip
        do_write(12'h04C, 32'hA5A5_5A5A);
        do_read("", 12'h04C);

        // R4/R6: seconds timebase loads and needs a full period
        do_write(12'h010, 32'd5);
        run_ticks(TPS - 1);
        do_read("R6 before period ", 12'h010);
        run_ticks(1);
        do_read("R4 after period ", 12'h010);

        // R5/R6: hundredths wrap from all ones
        do_write(12'h014, 32'hFFFF_FFFF);
        run_ticks(DIVF);
        chk("R5 hundredths wrap model", m_csec, 32'd0);
        do_read("R5 wrap ", 12'h014);

        // R8/R9: reload 3, tick through zero
        do_write(12'h01C, 32'd3);
        do_write(12'h018, 32'd100);
        run_ticks(3);
        do_read("R8 reached zero ", 12'h020);
        run_ticks(1);
        do_read("R8 reload ", 12'h020);
        do_read("R8 count after reload ", 12'h018);
        // R8: reload zero counts every tick
        do_write(12'h01C, 32'd0);
        run_ticks(5);
        do_read("R8 zero reload ", 12'h018);
        do_read("R9 ", 12'h01C);

        // R7: two-flop latency, read select held steady
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = 12'h008;
        btn_i = 4'b1011;
        #1 chk("R7 before any edge", prdata, {28'd0, m_btn});
        @(negedge clk);
        chk("R7 after first edge", prdata, {28'd0, m_btn});
        @(negedge clk);
        m_btn = btn_i;
        chk("R7 after second edge", prdata, 32'h0000_000B);
        psel = 1'b0;

        // R10: undecoded, misaligned and read-only writes change nothing
        do_write(12'h004, 32'hDEAD_BEEF);
        do_write(12'h011, 32'h1234_5678);
        do_write(12'h008, 32'hFFFF_FFFF);
        do_write(12'h020, 32'h0000_0077);
        do_write(12'hFFC, 32'h0000_0003);
        do_read("", 12'h004);
        do_read("", 12'h800);
        verify_all("R10 after bad writes ");

        // Random mix checked against the model
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom % 7;
            case (op)
                0: do_write(ofs_at($urandom % 8), $urandom);
                1: do_write(12'($urandom % 4096), $urandom);
                2: do_read("", ofs_at($urandom % 8));
                3: do_read("", 12'($urandom % 4096));
                4: run_ticks($urandom % 250);
                5: begin
                    btn_i = 4'($urandom);
                    m_btn = btn_i;
                    repeat (2) @(negedge clk);
                    do_read("", 12'h008);
                end
                default: do_write(12'h01C, $urandom % 6);
            endcase
            if (it % 25 == 24) verify_all("random ");
        end
        verify_all("final ");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule